// File: doc/BRIEF.md
# Binary Rate Multiplier

This block is a synchronous pulse-rate scaler. A free-running binary counter of `WIDTH` bits (four by default) advances once per enabled clock, and a `WIDTH`-bit rate word picks which counter states emit a one-clock output pulse. Over every full counter period of 16 enabled clocks, exactly N pulses come out, where N is the rate word. The output frequency is therefore the clock rate times N/16.

Each rate bit owns its own set of counter states, and these sets do not overlap. The weight-2^k bit owns 2^k states. The all-ones state belongs to no bit, so a less significant stage in a chain can place a pulse in that gap.

For chaining, the block has a hold input that freezes the stage, and a carry output that is raised while the counter sits at all-ones. It also has a blanking input, a force-high input, and synchronous clear and preset controls.

Top module: `brm_rate_mult`

## Requirements
- R1: After synchronous reset the counter is 0. In that state `pulse_o`=0, `pulse_n_o`=1, `carry_o`=0 and `full_o`=0.
- R2: With all controls low, the counter advances by one on each clock and wraps from 15 to 0. `full_o` is therefore high once in every 16 clocks.
- R3: Rate bit k (weight 2^k) claims counter state s when the low (WIDTH-k) bits of s equal 2^(WIDTH-1-k)-1. For WIDTH=4 these are: bit 3 claims even states; bit 2 claims s mod 4 = 1; bit 1 claims s mod 8 = 3; bit 0 claims state 7. `pulse_o` is high in the clock after an edge at which the counter held a claimed state whose rate bit is 1.
- R4: With several rate bits set, the pulse train is the union of the single-bit trains. Over 16 enabled clocks, exactly N pulses appear for every N from 0 to 15.
- R5: Counter state 15 never yields a pulse, whatever the rate word.
- R6: `full_o` is high exactly while the counter holds 15. `carry_o` is high exactly while the counter holds 15 and `hold_i` is low.
- R7: While `hold_i` is high (and neither clear nor preset is high), the counter and the pulse register keep their values.
- R8: While `blank_i` is high, `pulse_o` is 0 and `pulse_n_o` is 1 in that same cycle. The counter keeps advancing.
- R9: While `force_hi_i` is high, `pulse_o` is 1. `pulse_n_o` is not affected by it.
- R10: `preset_i` loads 15 at the next edge, and this overrides clear and hold. `clear_i` loads 0 at the next edge, and this overrides hold. Both of them drop the pulse register to idle.
- R11: With `force_hi_i` low, `pulse_n_o` is always the complement of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_i | input | WIDTH | Rate word N |
| hold_i | input | 1 | Inhibit: freezes the counter and the pulse register, and masks carry |
| blank_i | input | 1 | Forces the pulse outputs to their idle level |
| force_hi_i | input | 1 | Forces the true-polarity pulse output high |
| clear_i | input | 1 | Synchronous load of 0 |
| preset_i | input | 1 | Synchronous load of all-ones; has priority over clear |
| pulse_o | output | 1 | Pulse train, active high |
| pulse_n_o | output | 1 | Pulse train, active low |
| carry_o | output | 1 | Counter at all-ones and not held |
| full_o | output | 1 | Counter at all-ones |

## Verification
The main function is swept over all sixteen rate words. Each sweep starts from a cleared counter, and the bench compares every cycle of the train with a slot model it computes from modular arithmetic. The single-bit words (1, 2, 4, 8) show that each bit has its own slots and the right weight. The mixed words show that the trains combine as a union with no overlap. Word 15 shows that the all-ones slot stays empty. Separate patterns with hold, blanking, force-high, and clear racing preset show each override apart from the normal counting path. The counter position is read back only through `full_o`.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [1:0] {
    CNT_RUN   = 2'd0,
    CNT_HOLD  = 2'd1,
    CNT_CLEAR = 2'd2,
    CNT_SET   = 2'd3
  } cnt_op_e;

  // Preset beats clear, clear beats hold.
  function automatic cnt_op_e pick_op(input logic preset, input logic clear,
                                      input logic hold);
    if (preset)     return CNT_SET;
    else if (clear) return CNT_CLEAR;
    else if (hold)  return CNT_HOLD;
    else            return CNT_RUN;
  endfunction

endpackage

// File: rtl/brm_counter.sv
module brm_counter
  import brm_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op,
  output logic [WIDTH-1:0] cnt_q,
  output logic             full
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (op)
        CNT_SET:   cnt_q <= ALL_ONES;
        CNT_CLEAR: cnt_q <= '0;
        CNT_HOLD:  cnt_q <= cnt_q;
        default:   cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  assign full = (cnt_q == ALL_ONES);

endmodule

// File: rtl/brm_slot_select.sv
module brm_slot_select #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] rate,
  output logic             hit
);

  logic [WIDTH-1:0] slot;

  // Bit k compares the low SPAN bits of the state against 0 followed by ones.
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    localparam int unsigned SPAN = WIDTH - k;
    localparam int unsigned PAT  = (1 << (SPAN - 1)) - 1;
    localparam logic [SPAN-1:0] PAT_V = PAT[SPAN-1:0];
    assign slot[k] = rate[k] && (state[SPAN-1:0] == PAT_V);
  end

  assign hit = |slot;

endmodule

// File: rtl/brm_out_stage.sv
module brm_out_stage
  import brm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  cnt_op_e op,
  input  logic    hit,
  input  logic    blank,
  input  logic    force_hi,
  output logic    pulse,
  output logic    pulse_n
);

  logic pulse_q;
  logic live;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else begin
      unique case (op)
        CNT_SET, CNT_CLEAR: pulse_q <= 1'b0;
        CNT_HOLD:           pulse_q <= pulse_q;
        default:            pulse_q <= hit;
      endcase
    end
  end

  assign live    = pulse_q & ~blank;
  assign pulse   = live | force_hi;
  assign pulse_n = ~live;

endmodule

// File: rtl/brm_rate_mult.sv
module brm_rate_mult
  import brm_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rate_i,
  input  logic             hold_i,
  input  logic             blank_i,
  input  logic             force_hi_i,
  input  logic             clear_i,
  input  logic             preset_i,
  output logic             pulse_o,
  output logic             pulse_n_o,
  output logic             carry_o,
  output logic             full_o
);

  cnt_op_e          op;
  logic [WIDTH-1:0] cnt;
  logic             full;
  logic             hit;

  assign op = pick_op(preset_i, clear_i, hold_i);

  brm_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .cnt_q (cnt),
    .full  (full)
  );

  brm_slot_select #(.WIDTH(WIDTH)) u_sel (
    .state (cnt),
    .rate  (rate_i),
    .hit   (hit)
  );

  brm_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .hit      (hit),
    .blank    (blank_i),
    .force_hi (force_hi_i),
    .pulse    (pulse_o),
    .pulse_n  (pulse_n_o)
  );

  assign full_o  = full;
  assign carry_o = full & ~hold_i;

endmodule

// File: rtl/brm_rate_mult_chk.sv
module brm_rate_mult_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] rate_i,
  input logic             hold_i,
  input logic             blank_i,
  input logic             force_hi_i,
  input logic             clear_i,
  input logic             preset_i,
  input logic             pulse_o,
  input logic             pulse_n_o,
  input logic             carry_o,
  input logic             full_o
);

  AST_FULL_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    full_o && !hold_i && !clear_i && !preset_i |=> !full_o); // R2

  AST_LAST_SLOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    full_o && !hold_i && !clear_i && !preset_i |=> (!pulse_o || force_hi_i)); // R5

  AST_CARRY_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> full_o && !hold_i); // R6

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    hold_i && !clear_i && !preset_i |=> $stable(full_o)); // R7

  AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (rst)
    blank_i && !force_hi_i |-> !pulse_o && pulse_n_o); // R8

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    force_hi_i |-> pulse_o); // R9

  AST_PRESET_FULL: assert property (@(posedge clk) disable iff (rst)
    preset_i |=> full_o); // R10

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clear_i && !preset_i |=> !full_o && (!pulse_o || force_hi_i)); // R10

  AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (rst)
    !force_hi_i |-> (pulse_o != pulse_n_o)); // R11

endmodule

bind brm_rate_mult brm_rate_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rate_i     (rate_i),
  .hold_i     (hold_i),
  .blank_i    (blank_i),
  .force_hi_i (force_hi_i),
  .clear_i    (clear_i),
  .preset_i   (preset_i),
  .pulse_o    (pulse_o),
  .pulse_n_o  (pulse_n_o),
  .carry_o    (carry_o),
  .full_o     (full_o)
);

// File: tb/brm_rate_mult_bench.sv
module brm_rate_mult_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] rate_i;
  logic         hold_i, blank_i, force_hi_i, clear_i, preset_i;
  logic         pulse_o, pulse_n_o, carry_o, full_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brm_rate_mult #(.WIDTH(W)) u_brm_rate_mult (
    .clk(clk), .rst(rst), .rate_i(rate_i), .hold_i(hold_i),
    .blank_i(blank_i), .force_hi_i(force_hi_i), .clear_i(clear_i),
    .preset_i(preset_i), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o),
    .carry_o(carry_o), .full_o(full_o)
  );

  function automatic bit exp_hit(input int s, input int n);
    for (int k = 0; k < W; k++)
      if (n[k] && ((s % (16 >> k)) == ((8 >> k) - 1))) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt_p;
    rst = 1; rate_i = '0; hold_i = 0; blank_i = 0; force_hi_i = 0;
    clear_i = 0; preset_i = 0;
    repeat (3) step();
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 pulse_o", pulse_o, 0);
    chk("R1 pulse_n_o", pulse_n_o, 1);
    chk("R1 carry_o", carry_o, 0);
    chk("R1 full_o", full_o, 0);

    // R2 R3 R4 R5 R6 R11: sweep every rate word from a cleared counter
    for (int n = 0; n < 16; n++) begin
      rate_i = n[W-1:0];
      clear_i = 1; step(); clear_i = 0;
      cnt_p = 0;
      for (int i = 0; i < 16; i++) begin
        step();
        chk($sformatf("R3 n=%0d state=%0d pulse_o", n, i), pulse_o, exp_hit(i, n));
        chk("R11 polarity", pulse_n_o, !pulse_o);
        chk("R2 full_o position", full_o, (i == 14));
        chk("R6 carry_o", carry_o, (i == 14));
        if (i == 15) chk("R5 state 15 empty", pulse_o, 0);
        cnt_p += pulse_o;
      end
      chk($sformatf("R4 pulse count n=%0d", n), cnt_p, n);
    end

    // R7 hold freezes counter and pulse register
    rate_i = 4'd8;
    clear_i = 1; step(); clear_i = 0;
    step();                                  // state 0 -> pulse high, cnt=1
    chk("R7 pre-hold pulse", pulse_o, 1);
    hold_i = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 held pulse", pulse_o, 1);
    end
    hold_i = 0;
    step();                                  // state 1 -> no pulse
    chk("R7 resumed at state 1", pulse_o, 0);

    // R6 carry masked by hold at state 15
    clear_i = 1; step(); clear_i = 0;
    repeat (15) step();
    chk("R6 full at 15", full_o, 1);
    chk("R6 carry at 15", carry_o, 1);
    hold_i = 1; #1;
    chk("R6 carry masked", carry_o, 0);
    chk("R6 full kept", full_o, 1);
    step();
    chk("R7 counter held at 15", full_o, 1);
    hold_i = 0;

    // R8 blanking, counter keeps running
    rate_i = 4'd15;
    clear_i = 1; step(); clear_i = 0;
    step();
    chk("R8 pre-blank pulse", pulse_o, 1);
    blank_i = 1; #1;
    chk("R8 blank pulse_o", pulse_o, 0);
    chk("R8 blank pulse_n_o", pulse_n_o, 1);
    cnt_p = 0;
    for (int i = 0; i < 16; i++) begin
      step();
      cnt_p += pulse_o;
    end
    chk("R8 no pulses while blanked", cnt_p, 0);
    blank_i = 0;
    // cnt was 1 after first step, +16 -> 1; advance 14 more to reach 15
    repeat (14) step();
    chk("R8 counter kept advancing", full_o, 1);

    // R9 force-high, inverted output unaffected
    rate_i = 4'd0;
    clear_i = 1; step(); clear_i = 0;
    step();
    force_hi_i = 1; #1;
    chk("R9 forced pulse_o", pulse_o, 1);
    chk("R9 pulse_n_o untouched", pulse_n_o, 1);
    force_hi_i = 0;

    // R10 preset over clear and hold, then clear
    clear_i = 1; preset_i = 1; hold_i = 1;
    step();
    chk("R10 preset wins", full_o, 1);
    preset_i = 0;
    step();
    chk("R10 clear beats hold", full_o, 0);
    clear_i = 0; hold_i = 0;
    repeat (14) step();
    chk("R10 cleared to 0 (14 steps)", full_o, 0);
    step();
    chk("R10 cleared to 0 (15 steps)", full_o, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule